// File: doc/BRIEF.md
# Write-Allocate Miss Buffer with Store Merge

This unit handles misses for a non-blocking data cache that allocates on write and fetches the line before a store completes. Any load or store that misses is given one entry from a shared pool of miss buffers. That entry holds the line address, a per-byte mask and a line-wide store image. For each entry, the unit sends one line fill request to lower memory. Stores to a line whose fill is still pending are folded into the same entry. Younger bytes replace older ones.

The data array tracks validity only per whole line. For this reason the unit never writes a partial line. When a fill response comes back, the unit lays the buffered store bytes over the fetched line and writes the combined line in a single array write. In the same cycle it notifies the store side, or returns the requested word to the load side, tagged with the buffer index. Requesters do not retry. They hold their request until `req_ready` is high. `req_ready` stays low when the pool is full, when a load targets a line that is already pending, or when a store targets the entry that is retiring in that cycle.

Top module: `miss_merge_unit`

## Requirements
- R1: While reset is low and just after it, no buffer is in use: `fill_req_valid`, `arr_we`, `st_done_valid` and `ld_rsp_valid` are 0 and `req_ready` is 1.
- R2: An accepted request to a line with no pending entry takes the lowest-numbered free entry. That entry then raises `fill_req_valid` with its line and index. When several entries are unsent, the lowest index is offered first, and the offer is held while `fill_req_ready` is low.
- R3: A store to a line that already has a pending entry is accepted without a new fill request. It sets that entry's byte mask at positions `req_word*WORD_BYTES + j` for each set bit j of `req_be` and stores byte j of `req_wdata` there. A later store to the same byte replaces the earlier one.
- R4: One cycle after a fill response is accepted, `arr_we` is 1 and `arr_line` carries the entry's line. In `arr_data`, each byte b is the buffered store byte if mask bit b is set, and otherwise byte b of `fill_rsp_data`.
- R5: In the array-write cycle of an entry opened by a load, `ld_rsp_valid` is 1 with that entry's index. `ld_rsp_data` carries word `req_word` of the fetched line, not merged. A line that received no store is written unmodified.
- R6: In the array-write cycle of an entry that holds store bytes, `st_done_valid` is 1 with that entry's index.
- R7: When all entries are in use, a request to a line with no pending entry sees `req_ready` low. The entry is freed in its array-write cycle, so a stalled request is accepted on the following cycle.
- R8: A load to a line with a pending entry sees `req_ready` low until that entry retires. A store to the entry that is retiring in the current cycle is also held for that cycle.
- R9: Fill responses may return in any order. Each response is matched to its entry by `fill_rsp_id`.
- R10: A store that joins an entry opened by a load raises both completions in the same cycle. The load still receives the unmerged fetched word, and the array receives the merged line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_line | input | LADDR_W | Line address |
| req_word | input | log2(LINE_BYTES/WORD_BYTES) | Word index within the line |
| req_wdata | input | WORD_BYTES*8 | Store word |
| req_be | input | WORD_BYTES | Store byte enables |
| fill_req_valid | output | 1 | Fill request to lower memory |
| fill_req_ready | input | 1 | Lower memory takes the fill request |
| fill_req_line | output | LADDR_W | Line to fetch |
| fill_req_id | output | log2(NBUF) | Entry index of the request |
| fill_rsp_valid | input | 1 | Fill data returning |
| fill_rsp_ready | output | 1 | Fill response taken (always 1) |
| fill_rsp_id | input | log2(NBUF) | Entry the data belongs to |
| fill_rsp_data | input | LINE_BYTES*8 | Fetched line |
| arr_we | output | 1 | Data array write |
| arr_line | output | LADDR_W | Line written |
| arr_data | output | LINE_BYTES*8 | Merged line |
| st_done_valid | output | 1 | Store completion |
| st_done_id | output | log2(NBUF) | Entry completed |
| ld_rsp_valid | output | 1 | Load data return |
| ld_rsp_id | output | log2(NBUF) | Entry of the load |
| ld_rsp_data | output | WORD_BYTES*8 | Requested word |

## Verification
The assertions assume that lower memory behaves well. Every fill response names an entry that is in use and whose fill request has already been accepted, and no entry receives two responses. The bench's memory responder follows this rule: it answers only indices whose requests it has seen accepted, each one once, in a deliberately shuffled order. The requester may withdraw a stalled request, and the assertions do not assume that it holds the request. The bench withdraws stalled requests so that it can observe `req_ready` staying low, then presents them again.

// File: rtl/wamb_pkg.sv
// Package: default geometry shared by the miss buffer unit and its bench.
// Assumes LINE_BYTES is a multiple of WORD_BYTES and both are powers of two.
package wamb_pkg;
    localparam int NBUF_DEF       = 8;
    localparam int LINE_BYTES_DEF = 16;
    localparam int WORD_BYTES_DEF = 4;
    localparam int LADDR_W_DEF    = 26;
endpackage

// File: rtl/wamb_first.sv
// Module: lowest-index finder.
// Reports whether any bit of vec_i is set and the index of the lowest set bit.
// Assumes N >= 2.
module wamb_first #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    // Scan from the top down so the lowest set bit wins.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/wamb_merge.sv
// Module: byte-wise overlay of buffered store bytes on a fetched line.
// Pure combinational; assumes mask bit b governs byte b.
module wamb_merge #(
    parameter int LINE_BYTES = 16,
    localparam int LINE_BITS = LINE_BYTES * 8
) (
    input  logic [LINE_BITS-1:0]  fill_i,
    input  logic [LINE_BYTES-1:0] mask_i,
    input  logic [LINE_BITS-1:0]  store_i,
    output logic [LINE_BITS-1:0]  line_o
);
    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
        // Store byte if enabled, fetched byte otherwise.
        assign line_o[b*8 +: 8] = mask_i[b] ? store_i[b*8 +: 8] : fill_i[b*8 +: 8];
    end
endmodule

// File: rtl/wamb_slot.sv
// Module: one miss buffer entry.
// Holds flags, line address, requested word, byte mask and store image.
// Assumes alloc_i and retire_i are never both set, and that merge_i only
// arrives while the entry is valid.
module wamb_slot #(
    parameter int LINE_BYTES = 16,
    parameter int WORD_BYTES = 4,
    parameter int LADDR_W    = 26,
    localparam int WORDS     = LINE_BYTES / WORD_BYTES,
    localparam int WOFF_W    = $clog2(WORDS),
    localparam int LINE_BITS = LINE_BYTES * 8,
    localparam int WORD_BITS = WORD_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_i,
    input  logic                  merge_i,
    input  logic                  retire_i,
    input  logic                  sent_i,
    input  logic                  is_store_i,
    input  logic [LADDR_W-1:0]    line_i,
    input  logic [WOFF_W-1:0]     word_i,
    input  logic [WORD_BITS-1:0]  wdata_i,
    input  logic [WORD_BYTES-1:0] wbe_i,
    output logic                  valid_o,
    output logic                  sent_o,
    output logic                  load_o,
    output logic                  store_o,
    output logic [LADDR_W-1:0]    line_o,
    output logic [WOFF_W-1:0]     word_o,
    output logic [LINE_BYTES-1:0] mask_o,
    output logic [LINE_BITS-1:0]  data_o
);
    logic [LINE_BYTES-1:0] put_mask;
    logic [LINE_BITS-1:0]  put_data;

    // Spread the incoming store word to its byte lanes within the line.
    always_comb begin
        for (int b = 0; b < LINE_BYTES; b++) begin
            put_mask[b]       = (WOFF_W'(b / WORD_BYTES) == word_i) && wbe_i[b % WORD_BYTES];
            put_data[b*8 +: 8] = wdata_i[(b % WORD_BYTES)*8 +: 8];
        end
    end

    // Entry state: allocate, merge store bytes, mark fill sent, retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            sent_o  <= 1'b0;
            load_o  <= 1'b0;
            store_o <= 1'b0;
            line_o  <= '0;
            word_o  <= '0;
            mask_o  <= '0;
            data_o  <= '0;
        end else begin
            if (retire_i) begin
                valid_o <= 1'b0;
            end
            if (sent_i) begin
                sent_o <= 1'b1;
            end
            if (alloc_i) begin
                valid_o <= 1'b1;
                sent_o  <= 1'b0;
                load_o  <= !is_store_i;
                store_o <= is_store_i;
                line_o  <= line_i;
                word_o  <= word_i;
                mask_o  <= is_store_i ? put_mask : '0;
                for (int b = 0; b < LINE_BYTES; b++) begin
                    data_o[b*8 +: 8] <= (is_store_i && put_mask[b]) ? put_data[b*8 +: 8] : 8'h00;
                end
            end else if (merge_i) begin
                store_o <= 1'b1;
                mask_o  <= mask_o | put_mask;
                for (int b = 0; b < LINE_BYTES; b++) begin
                    if (put_mask[b]) begin
                        data_o[b*8 +: 8] <= put_data[b*8 +: 8];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/miss_merge_unit.sv
// Module: write-allocate miss buffer unit with store merge (top).
// A pool of NBUF entries serves load and store misses. Each entry issues one
// line fill. The returning line is overlaid with buffered store bytes and
// written whole, one cycle after the response. Assumes lower memory answers
// only entries whose fill was accepted, once each, in any order.
module miss_merge_unit
    import wamb_pkg::*;
#(
    parameter int NBUF       = NBUF_DEF,
    parameter int LINE_BYTES = LINE_BYTES_DEF,
    parameter int WORD_BYTES = WORD_BYTES_DEF,
    parameter int LADDR_W    = LADDR_W_DEF
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       req_valid,
    output logic                                       req_ready,
    input  logic                                       req_is_store,
    input  logic [LADDR_W-1:0]                         req_line,
    input  logic [$clog2(LINE_BYTES/WORD_BYTES)-1:0]   req_word,
    input  logic [WORD_BYTES*8-1:0]                    req_wdata,
    input  logic [WORD_BYTES-1:0]                      req_be,
    output logic                                       fill_req_valid,
    input  logic                                       fill_req_ready,
    output logic [LADDR_W-1:0]                         fill_req_line,
    output logic [$clog2(NBUF)-1:0]                    fill_req_id,
    input  logic                                       fill_rsp_valid,
    output logic                                       fill_rsp_ready,
    input  logic [$clog2(NBUF)-1:0]                    fill_rsp_id,
    input  logic [LINE_BYTES*8-1:0]                    fill_rsp_data,
    output logic                                       arr_we,
    output logic [LADDR_W-1:0]                         arr_line,
    output logic [LINE_BYTES*8-1:0]                    arr_data,
    output logic                                       st_done_valid,
    output logic [$clog2(NBUF)-1:0]                    st_done_id,
    output logic                                       ld_rsp_valid,
    output logic [$clog2(NBUF)-1:0]                    ld_rsp_id,
    output logic [WORD_BYTES*8-1:0]                    ld_rsp_data
);
    localparam int IDW       = $clog2(NBUF);
    localparam int WORDS     = LINE_BYTES / WORD_BYTES;
    localparam int WOFF_W    = $clog2(WORDS);
    localparam int LINE_BITS = LINE_BYTES * 8;
    localparam int WORD_BITS = WORD_BYTES * 8;

    logic [NBUF-1:0]       s_valid, s_sent, s_load, s_store;
    logic [NBUF-1:0]       hit_vec, alloc_vec, merge_vec, retire_vec, sent_vec;
    logic [LADDR_W-1:0]    s_line [NBUF];
    logic [WOFF_W-1:0]     s_word [NBUF];
    logic [LINE_BYTES-1:0] s_mask [NBUF];
    logic [LINE_BITS-1:0]  s_data [NBUF];

    logic                  hit_any, free_found, unsent_found, accept;
    logic [IDW-1:0]        hit_idx, free_idx, unsent_idx;

    logic                  rt_valid;
    logic [IDW-1:0]        rt_id;
    logic [LINE_BITS-1:0]  rt_fill;
    logic [LINE_BITS-1:0]  merged;

    for (genvar i = 0; i < NBUF; i++) begin : g_slot
        // Line match of the incoming request against this entry.
        assign hit_vec[i]    = s_valid[i] && (s_line[i] == req_line);
        assign alloc_vec[i]  = accept && !hit_any && (free_idx == IDW'(i));
        assign merge_vec[i]  = accept && req_is_store && hit_any && (hit_idx == IDW'(i));
        assign retire_vec[i] = rt_valid && (rt_id == IDW'(i));
        assign sent_vec[i]   = fill_req_valid && fill_req_ready && (unsent_idx == IDW'(i));

        wamb_slot #(
            .LINE_BYTES (LINE_BYTES),
            .WORD_BYTES (WORD_BYTES),
            .LADDR_W    (LADDR_W)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_i    (alloc_vec[i]),
            .merge_i    (merge_vec[i]),
            .retire_i   (retire_vec[i]),
            .sent_i     (sent_vec[i]),
            .is_store_i (req_is_store),
            .line_i     (req_line),
            .word_i     (req_word),
            .wdata_i    (req_wdata),
            .wbe_i      (req_be),
            .valid_o    (s_valid[i]),
            .sent_o     (s_sent[i]),
            .load_o     (s_load[i]),
            .store_o    (s_store[i]),
            .line_o     (s_line[i]),
            .word_o     (s_word[i]),
            .mask_o     (s_mask[i]),
            .data_o     (s_data[i])
        );
    end

    wamb_first #(.N(NBUF)) u_hit    (.vec_i(hit_vec),            .found_o(hit_any),      .idx_o(hit_idx));
    wamb_first #(.N(NBUF)) u_free   (.vec_i(~s_valid),           .found_o(free_found),   .idx_o(free_idx));
    wamb_first #(.N(NBUF)) u_unsent (.vec_i(s_valid & ~s_sent),  .found_o(unsent_found), .idx_o(unsent_idx));

    // Acceptance: merge stores into a pending line, else allocate if room.
    always_comb begin
        if (hit_any) begin
            req_ready = req_is_store && !(rt_valid && (rt_id == hit_idx));
        end else begin
            req_ready = free_found;
        end
    end
    assign accept = req_valid && req_ready;

    // Fill request: lowest unsent entry is offered to lower memory.
    assign fill_req_valid = unsent_found;
    assign fill_req_line  = s_line[unsent_idx];
    assign fill_req_id    = unsent_idx;
    assign fill_rsp_ready = 1'b1;

    // Retire stage: capture the returning line for next-cycle write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_valid <= 1'b0;
            rt_id    <= '0;
            rt_fill  <= '0;
        end else begin
            rt_valid <= fill_rsp_valid;
            rt_id    <= fill_rsp_id;
            rt_fill  <= fill_rsp_data;
        end
    end

    wamb_merge #(.LINE_BYTES(LINE_BYTES)) u_merge (
        .fill_i  (rt_fill),
        .mask_i  (s_mask[rt_id]),
        .store_i (s_data[rt_id]),
        .line_o  (merged)
    );

    // Array write and completions, all in the retire cycle.
    assign arr_we        = rt_valid;
    assign arr_line      = s_line[rt_id];
    assign arr_data      = merged;
    assign st_done_valid = rt_valid && s_store[rt_id];
    assign st_done_id    = rt_id;
    assign ld_rsp_valid  = rt_valid && s_load[rt_id];
    assign ld_rsp_id     = rt_id;
    assign ld_rsp_data   = rt_fill[s_word[rt_id]*WORD_BITS +: WORD_BITS];
endmodule

// File: rtl/wamb_checker.sv
// Module: property checker for miss_merge_unit, attached by bind.
// Assumes lower memory answers only accepted, still-pending entries.
module wamb_checker #(
    parameter int NBUF = 8,
    localparam int IDW = $clog2(NBUF)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            req_is_store,
    input logic            hit_any,
    input logic [NBUF-1:0] hit_vec,
    input logic [NBUF-1:0] slot_valid,
    input logic [NBUF-1:0] slot_sent,
    input logic            fill_req_valid,
    input logic            fill_req_ready,
    input logic [IDW-1:0]  fill_req_id,
    input logic            fill_rsp_valid,
    input logic            fill_rsp_ready,
    input logic [IDW-1:0]  fill_rsp_id,
    input logic            arr_we,
    input logic            st_done_valid,
    input logic            ld_rsp_valid
);
    AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R3
    AST_ONE_FILL_PER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req_valid && fill_req_ready) |=> !(fill_req_valid && fill_req_id == $past(fill_req_id))); // R3
    AST_RSP_TARGETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        fill_rsp_valid |-> (slot_valid[fill_rsp_id] && slot_sent[fill_rsp_id])); // R9
    AST_WRITE_FOLLOWS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_rsp_valid && fill_rsp_ready) |=> arr_we); // R4
    AST_WRITE_HAS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> $past(fill_rsp_valid && fill_rsp_ready)); // R4
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        ((&slot_valid) && !hit_any) |-> !req_ready); // R7
    AST_LOAD_PENDING_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_store && hit_any) |-> !req_ready); // R8
    AST_DONE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_done_valid || ld_rsp_valid) |-> arr_we); // R6
endmodule

bind miss_merge_unit wamb_checker #(.NBUF(NBUF)) u_wamb_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_is_store   (req_is_store),
    .hit_any        (hit_any),
    .hit_vec        (hit_vec),
    .slot_valid     (s_valid),
    .slot_sent      (s_sent),
    .fill_req_valid (fill_req_valid),
    .fill_req_ready (fill_req_ready),
    .fill_req_id    (fill_req_id),
    .fill_rsp_valid (fill_rsp_valid),
    .fill_rsp_ready (fill_rsp_ready),
    .fill_rsp_id    (fill_rsp_id),
    .arr_we         (arr_we),
    .st_done_valid  (st_done_valid),
    .ld_rsp_valid   (ld_rsp_valid)
);

// File: tb/miss_merge_unit_bench.sv
// Bench: behavioural reference model compared with the unit on every clock.
// Inputs change 1 ns after a rising edge; outputs are compared at the falling edge.
`timescale 1ns/100ps
module miss_merge_unit_bench;
    localparam int NB = 8;
    localparam int LB = 16;
    localparam int WB = 4;
    localparam int LA = 26;
    localparam int IW = 3;
    localparam int WO = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_is_store = 1'b0;
    logic [LA-1:0] req_line = '0;
    logic [WO-1:0] req_word = '0;
    logic [WB*8-1:0] req_wdata = '0;
    logic [WB-1:0] req_be = '0;
    logic          fill_req_ready = 1'b1;
    logic          fill_rsp_valid = 1'b0;
    logic [IW-1:0] fill_rsp_id = '0;
    logic [LB*8-1:0] fill_rsp_data = '0;
    logic          req_ready, fill_req_valid, fill_rsp_ready, arr_we, st_done_valid, ld_rsp_valid;
    logic [LA-1:0] fill_req_line, arr_line;
    logic [IW-1:0] fill_req_id, st_done_id, ld_rsp_id;
    logic [LB*8-1:0] arr_data;
    logic [WB*8-1:0] ld_rsp_data;

    always #2 clk = ~clk;

    miss_merge_unit u_miss_merge_unit (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_is_store(req_is_store),
        .req_line(req_line), .req_word(req_word), .req_wdata(req_wdata), .req_be(req_be),
        .fill_req_valid(fill_req_valid), .fill_req_ready(fill_req_ready),
        .fill_req_line(fill_req_line), .fill_req_id(fill_req_id),
        .fill_rsp_valid(fill_rsp_valid), .fill_rsp_ready(fill_rsp_ready),
        .fill_rsp_id(fill_rsp_id), .fill_rsp_data(fill_rsp_data),
        .arr_we(arr_we), .arr_line(arr_line), .arr_data(arr_data),
        .st_done_valid(st_done_valid), .st_done_id(st_done_id),
        .ld_rsp_valid(ld_rsp_valid), .ld_rsp_id(ld_rsp_id), .ld_rsp_data(ld_rsp_data)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    string tag = "R1";

    // Reference model state
    bit            m_valid [NB];
    bit            m_sent  [NB];
    bit            m_ld    [NB];
    bit            m_st    [NB];
    logic [LA-1:0] m_line  [NB];
    int            m_word  [NB];
    bit            m_be    [NB][LB];
    logic [7:0]    m_byte  [NB][LB];
    bit            m_rv;
    int            m_rid;
    logic [LB*8-1:0] m_rfill;

    // Expected values for the current cycle
    bit            e_ready, e_hit, e_frv, e_we, e_ld, e_st;
    int            e_hidx, e_free, e_fid;
    logic [LB*8-1:0] e_adata;
    logic [WB*8-1:0] e_lddata;

    function automatic logic [LB*8-1:0] pat(input logic [LA-1:0] line);
        logic [LB*8-1:0] r;
        for (int b = 0; b < LB; b++) r[b*8 +: 8] = 8'((int'(line) * 7 + b * 29 + 3) & 255);
        return r;
    endfunction

    task automatic eval();
        e_hit = 0; e_hidx = 0; e_free = -1; e_fid = -1;
        for (int i = NB - 1; i >= 0; i--) begin
            if (m_valid[i] && m_line[i] == req_line) begin e_hit = 1; e_hidx = i; end
            if (!m_valid[i]) e_free = i;
            if (m_valid[i] && !m_sent[i]) e_fid = i;
        end
        if (e_hit) e_ready = req_is_store && !(m_rv && m_rid == e_hidx);
        else       e_ready = (e_free >= 0);
        e_frv = (e_fid >= 0);
        e_we  = m_rv;
        e_ld  = m_rv && m_ld[m_rid];
        e_st  = m_rv && m_st[m_rid];
        for (int b = 0; b < LB; b++)
            e_adata[b*8 +: 8] = m_be[m_rid][b] ? m_byte[m_rid][b] : m_rfill[b*8 +: 8];
        e_lddata = m_rfill[m_word[m_rid]*WB*8 +: WB*8];
    endtask

    task automatic chk(input string what, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s at %0t: actual %h expected %h", req, what, $time, act, exp);
        end
    endtask

    task automatic put_store(input int k);
        m_st[k] = 1;
        for (int j = 0; j < WB; j++) begin
            if (req_be[j]) begin
                m_be[k][int'(req_word) * WB + j]   = 1;
                m_byte[k][int'(req_word) * WB + j] = req_wdata[j*8 +: 8];
            end
        end
    endtask

    // Compare every output with the model at the falling edge.
    always @(negedge clk) begin
        eval();
        chk("req_ready", tag, 128'(req_ready), 128'(e_ready));          // R7, R8
        chk("fill_req_valid", tag, 128'(fill_req_valid), 128'(e_frv)); // R2, R3
        if (e_frv) begin
            chk("fill_req_id", tag, 128'(fill_req_id), 128'(e_fid));   // R2
            chk("fill_req_line", tag, 128'(fill_req_line), 128'(m_line[e_fid]));
        end
        chk("arr_we", tag, 128'(arr_we), 128'(e_we));                  // R4
        if (e_we) begin
            chk("arr_line", tag, 128'(arr_line), 128'(m_line[m_rid]));
            chk("arr_data", tag, 128'(arr_data), 128'(e_adata));       // R4, R10
        end
        chk("ld_rsp_valid", tag, 128'(ld_rsp_valid), 128'(e_ld));      // R5
        if (e_ld) begin
            chk("ld_rsp_id", tag, 128'(ld_rsp_id), 128'(m_rid));
            chk("ld_rsp_data", tag, 128'(ld_rsp_data), 128'(e_lddata)); // R5, R10
        end
        chk("st_done_valid", tag, 128'(st_done_valid), 128'(e_st));    // R6
        if (e_st) chk("st_done_id", tag, 128'(st_done_id), 128'(m_rid));
    end

    // Advance the model on the rising edge with the expectations of the past cycle.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) begin
                m_valid[i] = 0; m_sent[i] = 0; m_ld[i] = 0; m_st[i] = 0;
                m_line[i] = '0; m_word[i] = 0;
                for (int b = 0; b < LB; b++) begin m_be[i][b] = 0; m_byte[i][b] = 8'h00; end
            end
            m_rv = 0; m_rid = 0; m_rfill = '0;
        end else begin
            if (m_rv) m_valid[m_rid] = 0;
            if (e_frv && fill_req_ready) m_sent[e_fid] = 1;
            if (req_valid && e_ready) begin
                if (e_hit) put_store(e_hidx);
                else begin
                    m_valid[e_free] = 1; m_sent[e_free] = 0;
                    m_ld[e_free] = !req_is_store; m_st[e_free] = 0;
                    m_line[e_free] = req_line; m_word[e_free] = int'(req_word);
                    for (int b = 0; b < LB; b++) begin m_be[e_free][b] = 0; m_byte[e_free][b] = 8'h00; end
                    if (req_is_store) put_store(e_free);
                end
            end
            m_rv = fill_rsp_valid; m_rid = int'(fill_rsp_id); m_rfill = fill_rsp_data;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Present a request, hold up to maxw cycles, then withdraw.
    task automatic send(input bit st, input int line, input int word,
                        input logic [31:0] wd, input logic [3:0] be, input int maxw);
        req_valid = 1; req_is_store = st; req_line = LA'(line); req_word = WO'(word);
        req_wdata = wd; req_be = be;
        for (int k = 0; k < maxw; k++) begin
            @(negedge clk); #0.5;
            if (e_ready) break;
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic respond(input int id);
        fill_rsp_valid = 1; fill_rsp_id = IW'(id); fill_rsp_data = pat(m_line[id]);
        @(posedge clk); #1;
        fill_rsp_valid = 0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        tag = "R1";
        idle(3);
        rst_n = 1;
        idle(2);
        // R2 / R5: single load miss and its return
        tag = "R2"; send(0, 'h100, 2, 0, 0, 4); idle(2);
        tag = "R5"; respond(0); idle(2);
        // R3 / R4: three stores to one line, overlapping bytes, one fill
        tag = "R3";
        send(1, 'h200, 1, 32'hAABBCCDD, 4'b0011, 4);
        send(1, 'h200, 1, 32'h11223344, 4'b0110, 4);
        send(1, 'h200, 3, 32'hDEADBEEF, 4'b1000, 4);
        idle(2);
        tag = "R4"; respond(0); idle(2);
        // R7: fill the pool with back-pressure on fill requests
        tag = "R7"; fill_req_ready = 0;
        for (int k = 0; k < NB; k++) send(0, 'h300 + k, k % 4, 0, 0, 4);
        idle(3); fill_req_ready = 1; idle(10);
        send(1, 'h3FF, 0, 32'h01020304, 4'hF, 3);
        // R9: out-of-order returns
        tag = "R9"; respond(5); respond(2); idle(1);
        tag = "R7"; send(1, 'h3FF, 0, 32'h01020304, 4'hF, 4); idle(3);
        // R8: load to pending line stalls
        tag = "R8"; send(0, 'h303, 1, 0, 0, 3); idle(1);
        // R10: store merges into a load entry
        tag = "R10"; send(1, 'h304, 0, 32'hCAFEF00D, 4'b0101, 4); idle(1); respond(4); idle(1);
        tag = "R9"; respond(7); respond(0); respond(1); respond(3); respond(6); respond(2); idle(2);
        tag = "R8"; send(0, 'h303, 1, 0, 0, 4); idle(3); respond(0); idle(3);
        summary();
    end
endmodule